// File: doc/BRIEF.md
# Cable Adaptor Identification Slave

This block is a standard-mode (100 kHz) I2C slave that answers at one fixed 7-bit bus address and holds a constant 17-byte identification table. A host reads the table to decide whether the attached cable adaptor can carry HDMI content or only DVI. A fast system clock samples SCL and SDA through synchronizers and a two-sample agreement filter. The block pulls SDA low with an output-enable signal and never drives it high.

A write transaction loads a one-byte offset into the read pointer. A read transaction streams table bytes starting at the pointer. The pointer steps forward each time the master acknowledges a byte and stays at the last entry once it gets there. The pointer returns to zero at reset and at every STOP. A read can therefore start straight away with the read address and no offset write before it.

An identification-enable input hides the slave completely. A low-power input idles the whole engine and leaves SDA released.

Top module: `adaptor_id_slave`

## Requirements
- R1: The slave acknowledges only address bytes 0x80 (write) and 0x81 (read), which are address 7'b1000000 followed by the direction bit. Every other address byte gets no ACK, and the slave stays silent until the next START.
- R2: The table at offsets 0x00 to 0x10 holds 0x44 0x50 0x2D 0x48 0x44 0x4D 0x49 0x20 0x41 0x44 0x41 0x50 0x54 0x4F 0x52 0x04 0xFF. Bytes are sent MSB first.
- R3: In a write, the slave acknowledges the offset byte that follows the address and loads it into the pointer. An offset above 0x10 is loaded as 0x10.
- R4: In a read, a master ACK (SDA low in the ninth clock) advances the pointer and starts the next byte. A master NACK makes the slave keep SDA released until the next START or STOP.
- R5: The pointer never goes past 0x10. Every further ACK at 0x10 resends 0xFF.
- R6: While the identification-enable input `id_en` is low, the slave does not acknowledge its address and returns no data (SDA stays released).
- R7: The pointer is 0x00 after reset and after every STOP, so a read issued without an offset write starts at 0x44.
- R8: While `active` is low, the slave ignores the bus and never pulls SDA low.
- R9: A START detected in the middle of a byte abandons that byte and starts address reception again.
- R10: The slave changes its SDA drive only while SCL is low, one system clock after it detects the SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled SCL bus line |
| sda_in | input | 1 | Sampled SDA bus line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| id_en | input | 1 | 1 makes the table visible; 0 hides the slave |
| active | input | 1 | 1 normal operation; 0 low-power idle |

## Verification
The hardest state to reach from the ports is the saturated pointer. The master has to acknowledge seventeen bytes in a row before the repeated 0xFF appears. The bench gets there in two ways: one long acknowledged read from offset 0, and an offset write of 0x0F or 0x20 followed by a repeated START into a read. The mid-byte abort is reached by sending four address bits and then raising SDA and forming a new START before the byte completes. A port monitor checks that the SDA drive never changes while the bench holds SCL high.

// File: rtl/adid_pkg.sv
package adid_pkg;

    localparam int               OFS_W    = 5;
    localparam logic [OFS_W-1:0] LAST_OFS = 5'd16;
    localparam logic [6:0]       DEF_ADDR = 7'b1000000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_OFS,
        ST_OFS_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } slv_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [7:0] id_byte(input logic [OFS_W-1:0] ofs);
        logic [7:0] v;
        case (ofs)
            5'd0:  v = 8'h44;
            5'd1:  v = 8'h50;
            5'd2:  v = 8'h2D;
            5'd3:  v = 8'h48;
            5'd4:  v = 8'h44;
            5'd5:  v = 8'h4D;
            5'd6:  v = 8'h49;
            5'd7:  v = 8'h20;
            5'd8:  v = 8'h41;
            5'd9:  v = 8'h44;
            5'd10: v = 8'h41;
            5'd11: v = 8'h50;
            5'd12: v = 8'h54;
            5'd13: v = 8'h4F;
            5'd14: v = 8'h52;
            5'd15: v = 8'h04;
            default: v = 8'hFF;
        endcase
        return v;
    endfunction

    function automatic logic [OFS_W-1:0] clamp_ofs(input logic [7:0] v);
        return (v > 8'(LAST_OFS)) ? LAST_OFS : v[OFS_W-1:0];
    endfunction

    function automatic logic [OFS_W-1:0] step_ofs(input logic [OFS_W-1:0] p);
        return (p == LAST_OFS) ? p : p + 1'b1;
    endfunction

endpackage

// File: rtl/adid_line_filter.sv
module adid_line_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= 1'b1;
            clean  <= 1'b1;
        end else begin
            sync_q <= {sync_q[TOP-1:0], raw};
            hist_q <= sync_q[TOP];
            if (sync_q[TOP] == hist_q)
                clean <= hist_q;
        end
    end
endmodule

// File: rtl/adid_bus_events.sv
module adid_bus_events
    import adid_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_c,
    input  logic    sda_c,
    output bus_ev_t ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_c;
            sda_p <= sda_c;
        end
    end

    always_comb begin
        ev.scl      = scl_c;
        ev.sda      = sda_c;
        ev.scl_rise = scl_c & ~scl_p;
        ev.scl_fall = ~scl_c & scl_p;
        ev.start    = scl_c & scl_p & sda_p & ~sda_c;
        ev.stop     = scl_c & scl_p & ~sda_p & sda_c;
    end
endmodule

// File: rtl/adid_id_rom.sv
module adid_id_rom
    import adid_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    output logic [7:0]       data
);
    always_comb data = id_byte(ofs);
endmodule

// File: rtl/adid_engine.sv
module adid_engine
    import adid_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = DEF_ADDR
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic             id_en,
    input  logic             active,
    input  logic [7:0]       rom_data,
    output logic [OFS_W-1:0] rom_ofs,
    output logic             sda_oe
);
    slv_state_e       state;
    logic [3:0]       bitcnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic [OFS_W-1:0] ptr;
    logic             rd_dir;
    logic             ack_low;

    always_comb rom_ofs = (state == ST_TX_ACK) ? step_ofs(ptr) : ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            rx_sh   <= '0;
            tx_sh   <= '1;
            ptr     <= '0;
            rd_dir  <= 1'b0;
            ack_low <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (!active) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_OFS: begin
                    if (ev.scl_rise && bitcnt != 4'd8) begin
                        rx_sh  <= {rx_sh[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.scl_fall && bitcnt == 4'd8) begin
                        if (state == ST_OFS) begin
                            ptr    <= clamp_ofs(rx_sh);
                            sda_oe <= 1'b1;
                            state  <= ST_OFS_ACK;
                        end else if (id_en && rx_sh[7:1] == SLAVE_ADDR) begin
                            rd_dir <= rx_sh[0];
                            sda_oe <= 1'b1;
                            state  <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (rd_dir) begin
                            tx_sh  <= {rom_data[6:0], 1'b1};
                            sda_oe <= ~rom_data[7];
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_OFS;
                        end
                    end
                end
                ST_OFS_ACK: begin
                    if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_HOLD;
                    end
                end
                ST_TX: begin
                    if (ev.scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            sda_oe <= ~tx_sh[7];
                            tx_sh  <= {tx_sh[6:0], 1'b1};
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_rise) begin
                        ack_low <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (ack_low) begin
                            ptr    <= step_ofs(ptr);
                            bitcnt <= '0;
                            tx_sh  <= {rom_data[6:0], 1'b1};
                            sda_oe <= ~rom_data[7];
                            state  <= ST_TX;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R5: pointer saturates at the last table entry
    assert_ptr_bound_R5: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST_OFS);

    // R6: address acknowledge only entered with the enable high
    assert_ack_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR_ACK && $past(state) != ST_ADDR_ACK) |-> $past(id_en));

    // R10: drive begins only while the filtered clock is low
    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    // R8: low-power input releases the line
    assert_quiet_lowpower_R8: assert property (@(posedge clk) disable iff (rst)
        !active |=> !sda_oe);

    // R7: STOP rewinds the pointer
    assert_stop_rewinds_R7: assert property (@(posedge clk) disable iff (rst)
        (active && ev.stop) |=> ptr == '0);

    // R4: a master NACK releases the line and parks the engine
    assert_nack_release_R4: assert property (@(posedge clk) disable iff (rst)
        (active && state == ST_TX_ACK && ev.scl_fall && !ack_low) |=> (!sda_oe && state == ST_HOLD));

endmodule

// File: rtl/adaptor_id_slave.sv
module adaptor_id_slave
    import adid_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = DEF_ADDR,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    input  logic id_en,
    input  logic active
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] clean_lines;
    bus_ev_t          ev;
    logic [OFS_W-1:0] rom_ofs;
    logic [7:0]       rom_data;

    always_comb raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_filt
        adid_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    adid_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_c (clean_lines[1]),
        .sda_c (clean_lines[0]),
        .ev    (ev)
    );

    adid_id_rom u_rom (
        .ofs  (rom_ofs),
        .data (rom_data)
    );

    adid_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .id_en    (id_en),
        .active   (active),
        .rom_data (rom_data),
        .rom_ofs  (rom_ofs),
        .sda_oe   (sda_oe)
    );
endmodule

// File: tb/adaptor_id_slave_test.sv
module adaptor_id_slave_test;
    localparam int Q      = 10;
    localparam int NVEC   = 7;
    localparam int WD_MAX = 150000;

    localparam logic [7:0] VEC_ADDR [NVEC] = '{8'h80, 8'h81, 8'h82, 8'h00, 8'hA1, 8'h01, 8'h41};
    localparam logic       VEC_ACK  [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

    logic clk = 0;
    logic rst = 1;
    logic m_scl = 1;
    logic m_sda = 1;
    logic id_en = 1;
    logic active = 1;
    logic sda_oe;
    wire  sda_bus = m_sda & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int edge_viol = 0;
    int lp_drive = 0;
    logic prev_oe = 0;
    logic [7:0] d;
    logic a;

    always #10 clk = ~clk;

    adaptor_id_slave uut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_oe(sda_oe), .id_en(id_en), .active(active)
    );

    always @(negedge clk) begin
        if (!rst && sda_oe != prev_oe && m_scl) edge_viol++;
        if (!rst && !active && sda_oe) lp_drive++;
        prev_oe <= sda_oe;
    end

    function automatic logic [7:0] exp_byte(input int i);
        case (i)
            0: return 8'h44;  1: return 8'h50;  2: return 8'h2D;  3: return 8'h48;
            4: return 8'h44;  5: return 8'h4D;  6: return 8'h49;  7: return 8'h20;
            8: return 8'h41;  9: return 8'h44; 10: return 8'h41; 11: return 8'h50;
           12: return 8'h54; 13: return 8'h4F; 14: return 8'h52; 15: return 8'h04;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1; wt(Q); m_scl = 1; wt(Q); m_sda = 0; wt(Q); m_scl = 0; wt(Q);
    endtask

    task automatic bus_stop;
        m_sda = 0; wt(Q); m_scl = 1; wt(Q); m_sda = 1; wt(Q);
    endtask

    task automatic wr_bit(input logic b);
        m_sda = b; wt(Q); m_scl = 1; wt(2 * Q); m_scl = 0; wt(Q);
    endtask

    task automatic rd_bit(output logic b);
        m_sda = 1; wt(Q); m_scl = 1; wt(Q); b = sda_bus; wt(Q); m_scl = 0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) wr_bit(v[i]);
        rd_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            rd_bit(b);
            v = {v[6:0], b};
        end
        wr_bit(~give_ack);
    endtask

    task automatic set_offset(input logic [7:0] ofs, input string req);
        bus_start;
        send_byte(8'h80, a);
        check8({req, " write address ack"}, {7'd0, a}, 8'd1);
        send_byte(ofs, a);
        check8({req, " offset ack"}, {7'd0, a}, 8'd1);
    endtask

    initial begin
        repeat (WD_MAX) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wt(5);
        rst = 0;
        wt(5);
        // reset state: line released (R7 pointer checked by shortcut read below)
        check8("R8 reset release", {7'd0, sda_oe}, 8'd0);

        // vector table: address match R1
        for (int v = 0; v < NVEC; v++) begin
            bus_start;
            send_byte(VEC_ADDR[v], a);
            check8("R1 address ack", {7'd0, a}, {7'd0, VEC_ACK[v]});
            if (a && VEC_ADDR[v][0]) begin
                recv_byte(d, 1'b0);
                check8("R7 shortcut read first byte", d, 8'h44);
            end else if (a) begin
                send_byte(8'h00, a);
                check8("R3 offset ack", {7'd0, a}, 8'd1);
            end
            bus_stop;
            wt(Q);
        end

        // R2 R5: full read from offset 0, past the end
        set_offset(8'h00, "R2");
        bus_start;
        send_byte(8'h81, a);
        check8("R2 read address ack", {7'd0, a}, 8'd1);
        for (int i = 0; i < 20; i++) begin
            recv_byte(d, i != 19);
            check8(i < 17 ? "R2 table byte" : "R5 saturated byte", d, exp_byte(i));
        end
        bus_stop;

        // R3: offset write then repeated start read
        set_offset(8'h05, "R3");
        bus_start;
        send_byte(8'h81, a);
        for (int i = 0; i < 3; i++) begin
            recv_byte(d, i != 2);
            check8("R3 offset read", d, exp_byte(5 + i));
        end
        bus_stop;

        // R3: clamped offset
        set_offset(8'h20, "R3 clamp");
        bus_start;
        send_byte(8'h81, a);
        recv_byte(d, 1'b1);
        check8("R3 clamped offset byte", d, 8'hFF);
        recv_byte(d, 1'b0);
        check8("R5 repeat after clamp", d, 8'hFF);
        bus_stop;

        // R5: cross the end from 0x0F
        set_offset(8'h0F, "R5");
        bus_start;
        send_byte(8'h81, a);
        recv_byte(d, 1'b1);
        check8("R5 byte 0x0F", d, 8'h04);
        recv_byte(d, 1'b1);
        check8("R5 byte 0x10", d, 8'hFF);
        recv_byte(d, 1'b0);
        check8("R5 byte held", d, 8'hFF);
        bus_stop;

        // R7: shortcut read after STOP starts at 0; R4 NACK then silence
        bus_start;
        send_byte(8'h81, a);
        recv_byte(d, 1'b1);
        check8("R7 shortcut byte 0", d, 8'h44);
        recv_byte(d, 1'b0);
        check8("R4 byte after ack", d, 8'h50);
        recv_byte(d, 1'b0);
        check8("R4 released after nack", d, 8'hFF);
        bus_stop;

        // R6: enable low hides the slave
        id_en = 0;
        bus_start;
        send_byte(8'h81, a);
        check8("R6 no address ack", {7'd0, a}, 8'd0);
        recv_byte(d, 1'b0);
        check8("R6 no data", d, 8'hFF);
        bus_stop;
        id_en = 1;

        // R8: low power ignores the bus
        active = 0;
        wt(Q);
        bus_start;
        send_byte(8'h81, a);
        check8("R8 no ack in low power", {7'd0, a}, 8'd0);
        recv_byte(d, 1'b0);
        check8("R8 no data in low power", d, 8'hFF);
        bus_stop;
        check8("R8 never drove", lp_drive[7:0], 8'd0);
        active = 1;
        wt(Q);

        // R9: START mid-byte restarts address reception
        bus_start;
        wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b0); wr_bit(1'b0);
        bus_start;
        send_byte(8'h81, a);
        check8("R9 ack after restart", {7'd0, a}, 8'd1);
        recv_byte(d, 1'b0);
        check8("R9 data after restart", d, 8'h44);
        bus_stop;

        // R10: drive never changed while SCL high
        check8("R10 edge discipline", edge_viol[7:0], 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule